// File: doc/BRIEF.md
# Halting Reloadable Range Counter

This block is an up counter made of identical narrow stages chained by a carry-enable path. After a synchronous clear it starts at zero. It climbs through ordinary binary values until it reaches the all-ones terminal value, and it stops there. While it waits, a terminal flag stays high. When an active-low go request arrives during that wait, the counter loads a fixed start value (63 by default) and climbs again. From then on it cycles through the 193 states 63..255 for as long as go requests keep arriving at the top.

Each stage has two enables. It steps only when its carry-enable and the shared count enable are both high. Its carry output depends only on its carry-enable and on its own all-ones state, and never on the count enable. The first stage's carry-enable is tied high. The last stage's carry output is the terminal flag. The flag therefore stays valid while counting is paused, and the control logic uses it to freeze the count and to qualify the reload.

Top module: `halt_range_counter`

## Requirements
- R1: While `clr_n` is low at a rising clock edge, the count becomes 0 on that edge. This takes priority over the reload and over counting.
- R2: After a clear, with `cnt_en` high, the count rises by one per clock through the values 1 to 62. No value is skipped.
- R3: In any state from 63 to 254 with `cnt_en` high, the next count is the current count plus one.
- R4: In state 255 with `go_n` high, the count stays at 255, whatever the value of `cnt_en`.
- R5: In state 255 with `go_n` low, the next count is 63, whatever the value of `cnt_en`.
- R6: In any state other than 255, `go_n` has no effect on the next count.
- R7: `at_max` is 1 exactly when the count is 255, whatever the value of `cnt_en`.
- R8: In any state below 255 with `cnt_en` low, the count holds.
- R9: When the low 4-bit stage holds 15 and counting is enabled, the upper stage increments on the same edge (for example 79 to 80). At all other times the upper stage holds, except on a clear or a reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| go_n | input | 1 | Restart request, active low, acted on only at terminal count |
| cnt_en | input | 1 | Master count enable, shared by all stages |
| count | output | 8 | Current count value |
| at_max | output | 1 | High while the count is 255 |

## Verification
The bench builds the block with its default parameters: two 4-bit stages and a start value of 63. With these values, one directed sweep from zero covers the binary run-up below the loop, every nibble carry into the upper stage, and the terminal hold. Directed cases then cover a hold with the enable toggling, a reload, a go pulse away from the top, a pause in the middle of the sequence, and a clear at the top with go asserted. A long seeded random phase then mixes all four inputs against a next-state function in the bench. It reaches reloads and holds that are paused and that fall on many different phases of the loop.

// File: rtl/range_ctr_pkg.sv
package range_ctr_pkg;

  // Controls shared by every counter stage.
  typedef struct packed {
    logic clear;   // force stage to zero
    logic load;    // take the stage's slice of the start value
    logic cnt_en;  // shared count enable (parallel to all stages)
  } stage_ctl_t;

endpackage

// File: rtl/rc_stage.sv
module rc_stage
  import range_ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  stage_ctl_t   ctl,
  input  logic         cy_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         cy_out
);

  logic [W-1:0] q_nx;
  logic         step;

  assign step = cy_en & ctl.cnt_en;

  always_comb begin
    q_nx = q;
    if (ctl.clear)     q_nx = '0;
    else if (ctl.load) q_nx = load_val;
    else if (step)     q_nx = q + W'(1);
  end

  always_ff @(posedge clk) begin
    q <= q_nx;
  end

  // The carry depends on the carry-enable and the all-ones state only.
  assign cy_out = cy_en & (&q);

  // R9: without a carry-enable the stage holds unless it is loaded.
  a_r9_carry_gate: assert property (@(posedge clk) disable iff (ctl.clear)
    (!ctl.load && !cy_en) |=> $stable(q));

endmodule

// File: rtl/rc_control.sv
module rc_control
  import range_ctr_pkg::*;
(
  input  logic       clr_n,
  input  logic       go_n,
  input  logic       cnt_en,
  input  logic       top_reached,
  output stage_ctl_t ctl
);

  always_comb begin
    ctl.clear  = ~clr_n;
    ctl.load   = clr_n & top_reached & ~go_n;
    ctl.cnt_en = cnt_en & ~top_reached;
  end

endmodule

// File: rtl/halt_range_counter.sv
module halt_range_counter
  import range_ctr_pkg::*;
#(
  parameter int STAGE_W   = 4,
  parameter int N_STAGES  = 2,
  parameter int START_VAL = 63
) (
  input  logic                        clk,
  input  logic                        clr_n,
  input  logic                        go_n,
  input  logic                        cnt_en,
  output logic [STAGE_W*N_STAGES-1:0] count,
  output logic                        at_max
);

  localparam int CNT_W = STAGE_W * N_STAGES;
  localparam logic [CNT_W-1:0] START_VEC = CNT_W'(START_VAL);

  stage_ctl_t        ctl;
  logic [N_STAGES:0] cy;

  assign cy[0] = 1'b1;

  rc_control u_ctl (
    .clr_n       (clr_n),
    .go_n        (go_n),
    .cnt_en      (cnt_en),
    .top_reached (cy[N_STAGES]),
    .ctl         (ctl)
  );

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    rc_stage #(.W(STAGE_W)) u_stage (
      .clk      (clk),
      .ctl      (ctl),
      .cy_en    (cy[g]),
      .load_val (START_VEC[g*STAGE_W +: STAGE_W]),
      .q        (count[g*STAGE_W +: STAGE_W]),
      .cy_out   (cy[g+1])
    );
  end

  assign at_max = cy[N_STAGES];

  // R1: a clear wins over everything else.
  a_r1_clear_zero: assert property (@(posedge clk)
    !clr_n |=> (count == '0));

  // R4: the count stays at the top while no go request is present.
  a_r4_hold_top: assert property (@(posedge clk) disable iff (!clr_n)
    (at_max && go_n) |=> (count == {CNT_W{1'b1}}));

  // R5: a go request at the top reloads the start value.
  a_r5_reload: assert property (@(posedge clk) disable iff (!clr_n)
    (at_max && !go_n) |=> (count == START_VEC));

  // R3: a single step below the top when enabled.
  a_r3_step: assert property (@(posedge clk) disable iff (!clr_n)
    (!at_max && cnt_en) |=> (count == $past(count) + CNT_W'(1)));

  // R8: with the enable low and below the top, the count holds.
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (!at_max && !cnt_en) |=> $stable(count));

  // R7: the flag follows the register contents, enable or not.
  a_r7_flag: assert property (@(posedge clk) disable iff (!clr_n)
    at_max == (count == {CNT_W{1'b1}}));

endmodule

// File: tb/test_halt_range_counter.sv
module test_halt_range_counter;

  logic       clk = 1'b0;
  logic       clr_n, go_n, cnt_en;
  logic [7:0] count;
  logic       at_max;

  int tests = 0;
  int fails = 0;
  int unsigned exp_q = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  halt_range_counter i_halt_range_counter (
    .clk    (clk),
    .clr_n  (clr_n),
    .go_n   (go_n),
    .cnt_en (cnt_en),
    .count  (count),
    .at_max (at_max)
  );

  function automatic int unsigned model_next(int unsigned q, logic c_n, logic g_n, logic en);
    if (!c_n)        return 0;
    if (q == 255)    return g_n ? 255 : 63;
    if (en)          return q + 1;
    return q;
  endfunction

  task automatic check(string tag, int unsigned act, int unsigned exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply inputs for one cycle, then compare after the edge.
  task automatic step(logic c_n, logic g_n, logic en);
    string tag;
    int unsigned prev;
    @(negedge clk);
    clr_n = c_n; go_n = g_n; cnt_en = en;
    prev = exp_q;
    exp_q = model_next(prev, c_n, g_n, en);
    if (!c_n)               tag = "R1";
    else if (prev == 255)   tag = g_n ? "R4" : "R5";
    else if (!en)           tag = g_n ? "R8" : "R6";
    else if (!g_n)          tag = "R6";
    else if ((prev & 15) == 15) tag = "R9";
    else if (prev < 63)     tag = "R2";
    else                    tag = "R3";
    @(posedge clk);
    #1;
    check(tag, count, exp_q);
    check("R7", at_max, (exp_q == 255) ? 1 : 0);
  endtask

  initial begin
    clr_n = 1'b0; go_n = 1'b1; cnt_en = 1'b0;
    void'($urandom(32'd20240613));
    // R1: reset state
    repeat (3) step(1'b0, 1'b1, 1'b1);
    // R2, R3, R9: full sweep from 0 to the top
    repeat (255) step(1'b1, 1'b1, 1'b1);
    // R4: hold at top with the enable toggling
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, i[0]);
    // R5: reload with the enable low
    step(1'b1, 1'b0, 1'b0);
    repeat (20) step(1'b1, 1'b1, 1'b1);
    // R8: pause in the middle of the sequence
    repeat (4) step(1'b1, 1'b1, 1'b0);
    // R6: go pulses away from the top, enabled and not
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    repeat (200) step(1'b1, 1'b1, 1'b1);
    // R1: a clear at the top beats a go request
    step(1'b0, 1'b0, 1'b1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 100) != 0, ($urandom % 10) > 1, ($urandom % 5) != 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        #(8 * 200000);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule